// File: doc/BRIEF.md
# Pipeline Stage Dependency Token Hub

This block keeps the load, compute and store stages of a decoupled accelerator pipeline in step. Tokens pass between the stages through four one-way counters: load to compute, compute to load, compute to store, and store to compute. A queue holds no data, only a count of outstanding tokens. Software puts the ordering into each instruction as flags. Wait flags name the queues that the instruction must take a token from before it runs. Push pulses add a token to a queue when a stage finishes its work.

Each stage holds a request together with its wait flags until it receives a go. Go is granted in the cycle in which every queue the stage waits on holds at least one token. In that same cycle, one token is taken from each of those queues. The usual pattern is as follows. Load pushes toward compute once its buffers are filled. Compute waits on that token and, when it is done, pushes back to load to free the input buffer and forward to store. Store waits on compute, writes out, and returns a token to compute. With two interleaved threads of such instructions, load, compute and store can overlap.

Top module: `dep_token_hub`

## Requirements
- R1: While rst is high, all four counts go to zero and overflow clears. Right after reset, a request that waits on any queue gets no go.
- R2: A push pulse on a queue that is not full, with no pop on that queue in the same cycle, raises that queue's count by one at the next clock edge. The push inputs map to queues as follows: ld_done_push feeds load-to-compute, ex_free_ld feeds compute-to-load, ex_feed_st feeds compute-to-store, and st_free_ex feeds store-to-compute.
- R3: A stage that requests with no wait flags receives go in the same cycle, and no count changes because of it.
- R4: A stage that waits on one queue keeps go low while that queue is empty. Once the count is nonzero it receives go in the same cycle, and the count falls by one at the edge. Load waits on compute-to-load, and store waits on compute-to-store.
- R5: When compute waits on both load-to-compute and store-to-compute, it receives go only when both queues are nonzero. Both counts then fall by one at the same edge.
- R6: With its request low, a stage never receives go, and its wait flags take no token.
- R7: A push and a pop on the same queue in the same cycle leave its count unchanged, even when the queue is full, and do not set overflow.
- R8: A count never goes above DEPTH. A push to a full queue without a pop on that queue leaves the count at DEPTH and sets overflow at the edge.
- R9: Once set, overflow stays high until reset.
- R10: The level output packs the counts as CW-bit fields, where CW = $clog2(DEPTH+1). Load-to-compute sits at index 0, compute-to-load at 1, compute-to-store at 2, and store-to-compute at 3. Field q occupies bits [q*CW +: CW].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_req | input | 1 | Load stage wants to issue |
| ld_wait_ex | input | 1 | Load must take a compute-to-load token |
| ld_done_push | input | 1 | Load finished; push load-to-compute |
| ex_req | input | 1 | Compute stage wants to issue |
| ex_wait_ld | input | 1 | Compute must take a load-to-compute token |
| ex_wait_st | input | 1 | Compute must take a store-to-compute token |
| ex_free_ld | input | 1 | Compute finished; push compute-to-load |
| ex_feed_st | input | 1 | Compute finished; push compute-to-store |
| st_req | input | 1 | Store stage wants to issue |
| st_wait_ex | input | 1 | Store must take a compute-to-store token |
| st_free_ex | input | 1 | Store finished; push store-to-compute |
| ld_go | output | 1 | Load may issue this cycle |
| ex_go | output | 1 | Compute may issue this cycle |
| st_go | output | 1 | Store may issue this cycle |
| level | output | 4*CW | Packed token counts, layout as in R10 |
| overflow | output | 1 | Sticky: a push hit a full queue |

## Verification
The bench builds the hub with DEPTH set to 3, so CW is 2. With that setting, a queue fills after three pushes, so the saturation, overflow and push-with-pop-at-full cases are reached within a few cycles. A 2-bit field is also narrow enough that a wrong field offset in the level port changes neighbouring counts in ways the checks can see.

// File: rtl/dep_pkg.sv
package dep_pkg;
  localparam int NQ = 4;
  localparam int NS = 3;
  // queue indices: also the field order of the level port
  localparam int Q_L2C = 0;
  localparam int Q_C2L = 1;
  localparam int Q_C2S = 2;
  localparam int Q_S2C = 3;
  // stage indices
  localparam int S_LD = 0;
  localparam int S_EX = 1;
  localparam int S_ST = 2;
endpackage

// File: rtl/tok_counter.sv
module tok_counter #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic [CW-1:0] count,
  output logic          nonempty,
  output logic          ovf_hit
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic full;
  assign full     = (count == FULL);
  assign nonempty = (count != '0);
  assign ovf_hit  = push && !pop && full;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (push && !pop && !full) begin
      count <= count + 1'b1;
    end else if (pop && !push && nonempty) begin
      count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/issue_gate.sv
module issue_gate #(
  parameter int NQ = 4
) (
  input  logic          req,
  input  logic [NQ-1:0] need,
  input  logic [NQ-1:0] avail,
  output logic          go,
  output logic [NQ-1:0] take
);
  logic missing;
  assign missing = |(need & ~avail);
  assign go      = req && !missing;
  assign take    = go ? need : '0;
endmodule

// File: rtl/dep_token_hub.sv
module dep_token_hub
  import dep_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_req,
  input  logic            ld_wait_ex,
  input  logic            ld_done_push,
  input  logic            ex_req,
  input  logic            ex_wait_ld,
  input  logic            ex_wait_st,
  input  logic            ex_free_ld,
  input  logic            ex_feed_st,
  input  logic            st_req,
  input  logic            st_wait_ex,
  input  logic            st_free_ex,
  output logic            ld_go,
  output logic            ex_go,
  output logic            st_go,
  output logic [NQ*CW-1:0] level,
  output logic            overflow
);
  logic [NQ-1:0] push, pop, avail, ovf_hit;
  logic [NS-1:0] req, go;
  logic [NQ-1:0] need [NS];
  logic [NQ-1:0] take [NS];

  always_comb begin
    push        = '0;
    push[Q_L2C] = ld_done_push;
    push[Q_C2L] = ex_free_ld;
    push[Q_C2S] = ex_feed_st;
    push[Q_S2C] = st_free_ex;
  end

  always_comb begin
    req       = '0;
    req[S_LD] = ld_req;
    req[S_EX] = ex_req;
    req[S_ST] = st_req;
    for (int s = 0; s < NS; s++) need[s] = '0;
    need[S_LD][Q_C2L] = ld_wait_ex;
    need[S_EX][Q_L2C] = ex_wait_ld;
    need[S_EX][Q_S2C] = ex_wait_st;
    need[S_ST][Q_C2S] = st_wait_ex;
  end

  for (genvar s = 0; s < NS; s++) begin : g_gate
    issue_gate #(.NQ(NQ)) u_gate (
      .req  (req[s]),
      .need (need[s]),
      .avail(avail),
      .go   (go[s]),
      .take (take[s])
    );
  end

  always_comb begin
    pop = '0;
    for (int s = 0; s < NS; s++) pop = pop | take[s];
  end

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    tok_counter #(.DEPTH(DEPTH)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .push    (push[q]),
      .pop     (pop[q]),
      .count   (level[q*CW +: CW]),
      .nonempty(avail[q]),
      .ovf_hit (ovf_hit[q])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)           overflow <= 1'b0;
    else if (|ovf_hit) overflow <= 1'b1;
  end

  assign ld_go = go[S_LD];
  assign ex_go = go[S_EX];
  assign st_go = go[S_ST];
endmodule

// File: rtl/dep_token_hub_chk.sv
module dep_token_hub_chk
  import dep_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             ld_req,
  input logic             ld_wait_ex,
  input logic             ld_done_push,
  input logic             ex_req,
  input logic             ex_wait_ld,
  input logic             ex_wait_st,
  input logic             ex_free_ld,
  input logic             ex_feed_st,
  input logic             st_req,
  input logic             st_wait_ex,
  input logic             st_free_ex,
  input logic             ld_go,
  input logic             ex_go,
  input logic             st_go,
  input logic [NQ*CW-1:0] level,
  input logic             overflow
);
  logic [CW-1:0] c_l2c, c_c2l, c_c2s, c_s2c;
  assign c_l2c = level[Q_L2C*CW +: CW];
  assign c_c2l = level[Q_C2L*CW +: CW];
  assign c_c2s = level[Q_C2S*CW +: CW];
  assign c_s2c = level[Q_S2C*CW +: CW];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (level == '0 && !overflow));

  // R2
  l2c_push_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_done_push && !(ex_go && ex_wait_ld) && c_l2c != CW'(DEPTH))
    |=> c_l2c == $past(c_l2c) + 1'b1);

  // R4
  ld_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_go && ld_wait_ex) |-> c_c2l != '0);

  // R5
  ex_both_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_go && ex_wait_ld && ex_wait_st) |-> (c_l2c != '0 && c_s2c != '0));

  // R6
  no_req_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_req |-> !ld_go) and (!ex_req |-> !ex_go) and (!st_req |-> !st_go));

  // R7
  c2s_net_chk: assert property (@(posedge clk) disable iff (rst)
    (st_go && st_wait_ex && ex_feed_st) |=> $stable(c_c2s));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (c_l2c <= CW'(DEPTH)) && (c_c2l <= CW'(DEPTH)) &&
    (c_c2s <= CW'(DEPTH)) && (c_s2c <= CW'(DEPTH)));

  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
endmodule

bind dep_token_hub dep_token_hub_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_dep_token_hub.sv
module tb_dep_token_hub;
  localparam int DEPTH = 3;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_req = 0, ld_wait_ex = 0, ld_done_push = 0;
  logic ex_req = 0, ex_wait_ld = 0, ex_wait_st = 0, ex_free_ld = 0, ex_feed_st = 0;
  logic st_req = 0, st_wait_ex = 0, st_free_ex = 0;
  logic ld_go, ex_go, st_go, overflow;
  logic [4*CW-1:0] level;

  always #4 clk = ~clk;

  dep_token_hub #(.DEPTH(DEPTH)) dut (.*);

  typedef struct {
    logic [2:0]      go;
    logic [4*CW-1:0] lvl;
    logic            ovf;
    string           tag;
  } exp_t;

  exp_t sbq[$];
  int mcount[4];
  bit movf;
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [4*CW-1:0] pack_model();
    logic [4*CW-1:0] v;
    for (int q = 0; q < 4; q++) v[q*CW +: CW] = CW'(mcount[q]);
    return v;
  endfunction

  task automatic reset_dut();
    @(negedge clk);
    rst = 1'b1;
    {ld_req, ld_wait_ex, ld_done_push, ex_req, ex_wait_ld, ex_wait_st} = '0;
    {ex_free_ld, ex_feed_st, st_req, st_wait_ex, st_free_ex} = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int q = 0; q < 4; q++) mcount[q] = 0;
    movf = 0;
  endtask

  // queue index: 0 l2c, 1 c2l, 2 c2s, 3 s2c
  task automatic step(input string tag,
                      input bit lr, lw, lp,
                      input bit er, ewl, ews, efl, efs,
                      input bit sr, sw, sf);
    exp_t e;
    bit g_ld, g_ex, g_st;
    bit [3:0] pu, po;
    @(negedge clk);
    ld_req = lr; ld_wait_ex = lw; ld_done_push = lp;
    ex_req = er; ex_wait_ld = ewl; ex_wait_st = ews; ex_free_ld = efl; ex_feed_st = efs;
    st_req = sr; st_wait_ex = sw; st_free_ex = sf;
    g_ld = lr && (!lw || mcount[1] > 0);
    g_ex = er && (!ewl || mcount[0] > 0) && (!ews || mcount[3] > 0);
    g_st = sr && (!sw || mcount[2] > 0);
    pu = {sf, efs, efl, lp};
    po = {g_ex && ews, g_st && sw, g_ld && lw, g_ex && ewl};
    for (int q = 0; q < 4; q++) begin
      if (pu[q] && !po[q]) begin
        if (mcount[q] == DEPTH) movf = 1;
        else mcount[q]++;
      end else if (po[q] && !pu[q]) begin
        mcount[q]--;
      end
    end
    e.go = {g_st, g_ex, g_ld};
    e.lvl = pack_model();
    e.ovf = movf;
    e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(tag, 0,0,0, 0,0,0,0,0, 0,0,0);
  endtask

  // monitor: go sampled mid-cycle, state sampled after the edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq[0];
        checks++;
        if ({st_go, ex_go, ld_go} !== e.go) begin
          fails++;
          $display("FAIL %s go: actual %b expected %b", e.tag, {st_go, ex_go, ld_go}, e.go);
        end
        @(posedge clk);
        #1;
        void'(sbq.pop_front());
        checks++;
        if (level !== e.lvl) begin
          fails++;
          $display("FAIL %s level: actual %h expected %h", e.tag, level, e.lvl);
        end
        checks++;
        if (overflow !== e.ovf) begin
          fails++;
          $display("FAIL %s overflow: actual %b expected %b", e.tag, overflow, e.ovf);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    reset_dut();
    // R1: empty after reset, waiting requests blocked
    idle("R1");
    step("R1", 1,1,0, 1,1,1,0,0, 1,1,0);
    // R3: no wait flags -> immediate go
    step("R3", 1,0,0, 1,0,0,0,0, 1,0,0);
    // R2: pushes
    step("R2", 1,0,1, 0,0,0,0,0, 0,0,0);
    // R4: compute waits on l2c, token present
    step("R4", 0,0,0, 1,1,0,0,0, 0,0,0);
    step("R4", 0,0,0, 1,1,0,0,0, 0,0,0);
    // R5: dual wait
    step("R5", 0,0,1, 0,0,0,0,0, 0,0,0);
    step("R5", 0,0,0, 1,1,1,0,0, 0,0,0);
    step("R5", 0,0,0, 0,0,0,0,0, 0,0,1);
    step("R5", 0,0,0, 1,1,1,1,1, 0,0,0);
    // R6: flags without request take nothing
    step("R6", 0,1,0, 0,0,0,0,0, 0,1,0);
    // R4: load and store consume their tokens
    step("R4", 1,1,0, 0,0,0,0,0, 1,1,0);
    step("R4", 0,0,0, 0,0,0,0,0, 1,1,0);
    // R7: push and pop together on c2s
    step("R7", 0,0,0, 0,0,0,0,1, 0,0,0);
    step("R7", 0,0,0, 0,0,0,0,1, 1,1,0);
    // R10: distinct counts per field
    step("R10", 0,0,1, 0,0,0,1,1, 0,0,0);
    step("R10", 0,0,0, 0,0,0,1,1, 0,0,0);
    // R8: fill c2l to DEPTH then push+pop at full
    step("R8", 0,0,0, 0,0,0,1,0, 0,0,0);
    step("R7", 1,1,0, 0,0,0,1,0, 0,0,0);
    // R8: push to full sets overflow
    step("R8", 0,0,0, 0,0,0,1,0, 0,0,0);
    // R9: sticky
    idle("R9");
    step("R9", 1,1,0, 0,0,0,0,0, 0,0,0);
    idle("R9");
    wait (sbq.size() == 0);
    @(posedge clk);
    #2;
    // R1: reset clears everything again
    reset_dut();
    idle("R1");
    step("R1", 1,1,0, 0,0,0,0,0, 0,0,0);
    // R3/R5: compute with one of two tokens only
    step("R5", 0,0,0, 0,0,0,0,0, 0,0,1);
    step("R5", 0,0,0, 1,1,1,0,0, 0,0,0);
    step("R3", 0,0,0, 1,0,0,0,0, 0,0,0);
    wait (sbq.size() == 0);
    @(posedge clk);
    #2;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule